// File: doc/BRIEF.md
# Clocked Trigger Pulse Delay and Stretcher

This block turns a set of asynchronous hit signals into clean pulses that are aligned to the logic clock. Each hit line is brought into the clock domain and its rising edge is found. The edge is then held back by a programmable number of clock periods and widened into an output pulse of programmable length. One control byte sets the width and the delay for every channel, but each channel keeps its own delay stages and its own width counter. Channels therefore never interfere with each other.

Several boards can drive this logic from one shared clock and so produce pulses that line up. Because each input is sampled, an output may move by up to one clock period relative to its input. Clock source selection, level conversion and register access are handled elsewhere.

Top module: `trig_stretch_delay`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, every bit of `trig_out` is 0.
- R2: There are `NUM_CH` (8 by default) channels. Bit i of `trig_out` depends only on bit i of `hit_async` and on `ctrl`.
- R3: The width field is `ctrl[3:0]` (value W, 0 to 15). A single edge gives a pulse exactly W+1 clocks long, so W=0 gives a one-clock pulse. The W used is the value present when the delayed edge reaches the counter.
- R4: The delay field is `ctrl[7:4]` (value D, 0 to 15). An input that goes high before clock edge k, and is first sampled there, makes the output high right after clock edge k+2+D.
- R5: Only a low-to-high change of an input starts a pulse. An input that stays high, or that falls, starts nothing further.
- R6: If a delayed edge reaches a channel whose output is already high, the width count reloads with W. The pulse then lasts W+1 clocks from that point, with no low gap between the two pulses.
- R7: Every edge is kept for any D from 0 to 15, even when edges arrive every second clock, which is the closest spacing the edge detector can produce.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock, either internal or shared between boards |
| rst | input | 1 | Synchronous reset, active high |
| hit_async | input | NUM_CH | Asynchronous hit lines, one per channel |
| ctrl | input | 8 | Control byte: bits 7:4 set the delay, bits 3:0 set the width, both in clocks |
| trig_out | output | NUM_CH | Registered, delayed and stretched pulse for each channel |

## Verification
The bench uses the default eight channels and four-bit fields. This makes the whole range of 16 delays and 16 widths reachable, including the deepest tap, where W=0 and D=15 expose an off-by-one in the tap choice or the counter. With all eight channels active under a pseudo-random pattern, any crosstalk between channels would show up. A change of the control byte during random traffic checks that the delay tap is chosen live and that the width is captured at reload.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

    localparam int WIDTH_W   = 4;
    localparam int DELAY_W   = 4;
    localparam int TAP_COUNT = 1 << DELAY_W;

    typedef struct packed {
        logic [DELAY_W-1:0] delay;
        logic [WIDTH_W-1:0] width;
    } trig_cfg_t;

    localparam int CFG_W = $bits(trig_cfg_t);

    function automatic logic count_done(input logic [WIDTH_W-1:0] c);
        return (c == '0);
    endfunction

endpackage

// File: rtl/trig_sync_edge.sv
`timescale 1ns/1ps
module trig_sync_edge #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit_async,
    output logic [NUM_CH-1:0] edge_det
);
    logic [NUM_CH-1:0] meta_q;
    logic [NUM_CH-1:0] sync_q;
    logic [NUM_CH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= hit_async;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign edge_det = sync_q & ~last_q;

endmodule

// File: rtl/trig_delay_line.sv
`timescale 1ns/1ps
module trig_delay_line
    import trig_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CH-1:0]  edge_det,
    input  logic [DELAY_W-1:0] delay_sel,
    output logic [NUM_CH-1:0]  fire
);
    localparam int STAGES = TAP_COUNT - 1;

    logic [NUM_CH-1:0] stage_q [1:STAGES];
    logic [NUM_CH-1:0] taps    [0:STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k <= STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[1] <= edge_det;
            for (int k = 2; k <= STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign taps[0] = edge_det;
    generate
        for (genvar g = 1; g <= STAGES; g++) begin : g_tap
            assign taps[g] = stage_q[g];
        end
    endgenerate

    assign fire = taps[delay_sel];

endmodule

// File: rtl/trig_stretch.sv
`timescale 1ns/1ps
module trig_stretch
    import trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse
);
    logic               active_q;
    logic [WIDTH_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            remain_q <= '0;
        end else if (fire) begin
            active_q <= 1'b1;
            remain_q <= width;
        end else if (active_q) begin
            if (count_done(remain_q)) active_q <= 1'b0;
            else                      remain_q <= remain_q - 1'b1;
        end
    end

    assign pulse = active_q;

endmodule

// File: rtl/trig_stretch_delay.sv
`timescale 1ns/1ps
module trig_stretch_delay
    import trig_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit_async,
    input  logic [CFG_W-1:0]  ctrl,
    output logic [NUM_CH-1:0] trig_out
);
    trig_cfg_t         cfg;
    logic [NUM_CH-1:0] edge_v;
    logic [NUM_CH-1:0] fire_v;

    assign cfg = trig_cfg_t'(ctrl);

    trig_sync_edge #(.NUM_CH(NUM_CH)) u_sync (
        .clk(clk), .rst(rst), .hit_async(hit_async), .edge_det(edge_v)
    );

    trig_delay_line #(.NUM_CH(NUM_CH)) u_delay (
        .clk(clk), .rst(rst), .edge_det(edge_v), .delay_sel(cfg.delay), .fire(fire_v)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            trig_stretch u_stretch (
                .clk(clk), .rst(rst), .fire(fire_v[c]), .width(cfg.width), .pulse(trig_out[c])
            );
        end
    endgenerate

endmodule

// File: rtl/trig_stretch_delay_chk.sv
`timescale 1ns/1ps
module trig_stretch_delay_chk
    import trig_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] edge_v,
    input logic [NUM_CH-1:0] fire_v,
    input logic [CFG_W-1:0]  ctrl,
    input logic [NUM_CH-1:0] trig_out
);
    trig_cfg_t cfg;
    assign cfg = trig_cfg_t'(ctrl);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (trig_out == '0));

    assert_fire_raises_R4: assert property (@(posedge clk) disable iff (rst)
        (|fire_v) |=> ((trig_out & $past(fire_v)) == $past(fire_v)));

    assert_rise_needs_fire_R5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((trig_out & ~$past(trig_out) & ~$past(fire_v)) == '0));

    assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
        (|edge_v) |=> ((edge_v & $past(edge_v)) == '0));

    assert_no_drop_on_reload_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((~trig_out & $past(trig_out) & $past(fire_v)) == '0));

    assert_min_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        ((|fire_v) && cfg.width == '0) |=> ##1
        ((trig_out & $past(fire_v, 2) & ~$past(fire_v)) == '0));

endmodule

bind trig_stretch_delay trig_stretch_delay_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .edge_v(edge_v), .fire_v(fire_v), .ctrl(ctrl), .trig_out(trig_out)
);

// File: tb/trig_stretch_delay_bench.sv
`timescale 1ns/1ps
module trig_stretch_delay_bench;
    localparam int NCH  = 8;
    localparam int HIST = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] hit = '0;
    logic [7:0]     ctrl = '0;
    logic [NCH-1:0] trig_out;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_en = 1'b0;
    string cur_req = "R1";

    logic [NCH-1:0] hist [0:HIST-1];
    int             rem  [0:NCH-1];
    logic [NCH-1:0] exp_q = '0;

    trig_stretch_delay #(.NUM_CH(NCH)) u_trig_stretch_delay (
        .clk(clk), .rst(rst), .hit_async(hit), .ctrl(ctrl), .trig_out(trig_out)
    );

    always #2 clk = ~clk;

    // Behavioural reference: input history per sampling edge, remaining high cycles per channel
    always @(posedge clk) begin
        int d;
        int w;
        d = int'(ctrl[7:4]);
        w = int'(ctrl[3:0]);
        if (rst) begin
            for (int j = 0; j < HIST; j++) hist[j] = '0;
            for (int c = 0; c < NCH; c++) rem[c] = 0;
        end else begin
            for (int j = HIST-1; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = hit;
            for (int c = 0; c < NCH; c++) begin
                if (hist[2+d][c] && !hist[3+d][c]) rem[c] = w + 1;
                else if (rem[c] > 0) rem[c] = rem[c] - 1;
            end
        end
        for (int c = 0; c < NCH; c++) exp_q[c] = (rem[c] > 0);
    end

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            checks++;
            if (trig_out !== exp_q) begin
                errors++;
                $display("FAIL %s: trig_out=%b expected=%b at %0t", cur_req, trig_out, exp_q, $time);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_val(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One edge on a channel; measure rise time and pulse length at the port
    task automatic measure(input int ch, input int w, input int d);
        int rise;
        int len;
        ctrl = {d[3:0], w[3:0]};
        tick(24);
        hit[ch] = 1'b1;
        rise = -1;
        len  = 0;
        for (int k = 1; k <= 50; k++) begin
            @(negedge clk);
            if (k == 2) hit[ch] = 1'b0;
            if (trig_out[ch]) begin
                len++;
                if (rise < 0) rise = k;
            end
        end
        check_val("R4 latency", rise, 3 + d);
        check_val("R3 width", len, w + 1);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        tick(3);
        check_val("R1 reset", int'(trig_out), 0);
        tick(2);
        rst = 1'b0;
        cmp_en = 1'b1;
        tick(1);
        check_val("R1 after reset", int'(trig_out), 0);

        cur_req = "R3/R4";
        measure(0, 0, 0);
        measure(3, 5, 0);
        measure(5, 15, 3);
        measure(7, 2, 15);
        measure(1, 0, 15);

        // R5: held-high input gives one pulse only
        cur_req = "R5";
        ctrl = {4'd1, 4'd3};
        tick(20);
        hit[2] = 1'b1;
        tick(30);
        check_val("R5 held high quiet", int'(trig_out[2]), 0);
        hit[2] = 1'b0;
        tick(20);
        check_val("R5 falling ignored", int'(trig_out[2]), 0);

        // R6: retrigger extends
        cur_req = "R6";
        ctrl = {4'd2, 4'd6};
        hit[4] = 1'b1; tick(1); hit[4] = 1'b0; tick(3);
        hit[4] = 1'b1; tick(1); hit[4] = 1'b0;
        tick(25);

        // R7: edges every other clock at maximum delay
        cur_req = "R7";
        ctrl = {4'd15, 4'd0};
        for (int i = 0; i < 24; i++) begin
            hit[6] = ~hit[6];
            hit[0] = hit[6];
            tick(1);
        end
        hit = '0;
        tick(30);

        // R2: independent channels under pseudo-random traffic, control changes mid-stream
        cur_req = "R2";
        lfsr = 32'h1234_5679;
        for (int cfgi = 0; cfgi < 4; cfgi++) begin
            case (cfgi)
                0: ctrl = {4'd0, 4'd1};
                1: ctrl = {4'd7, 4'd4};
                2: ctrl = {4'd15, 4'd15};
                default: ctrl = {4'd3, 4'd0};
            endcase
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                hit = lfsr[7:0] & lfsr[19:12];
                if (i == 200) ctrl = ctrl ^ 8'h52;
                tick(1);
            end
        end
        hit = '0;
        tick(40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule